// File: doc/BRIEF.md
# Early/Late Bit-Clock Recovery with NRZI Word Packer

This block recovers the bit clock of a 1200 bit/s audio-FSK link from the hard-limited demodulator output. A base timing tick drives an adjustable sample timer. Every second or third sample is a decision sample, depending on the mode; the rest are intermediate samples. Software mode takes three samples per bit with a nominal period of 4 ticks. Hardware-squelch mode takes two samples per bit with a nominal period of 6 ticks.

At each decision sample, the recent transition history stretches or shrinks the next sample period by one tick. This pulls the decision point toward mid-symbol. Decided samples are NRZI-decoded and packed least-significant-bit first into 16-bit words, and each word is announced with a one-cycle strobe. A signed counter tracks the net number of late and early corrections. It saturates at its limits and can be cleared.

Top module: `dpll_nrzi_rx`

## Requirements
- R1: A sample is taken on the tick that completes the current period, where the period is the nominal value (4 in software mode `mode_hw_i`=0, 6 in hardware-squelch mode `mode_hw_i`=1) plus the pending correction. The sample phase runs 0,1,2,0 in software mode and 0,1,0 in hardware-squelch mode. Phase 0 is the decision sample, and the first sample after reset is a decision.
- R2: After an intermediate sample, the next period is nominal.
- R3: History bit 0 is 1 when the newest sample differs from the one before it, and older samples move to higher bits. In software mode, a decision sample whose 3-bit history is 001 (late) sets the next period to 5. A history of 100 (early) sets it to 3. Any other history sets it to 4.
- R4: In hardware-squelch mode, a decision sample whose 2-bit history is 01 (late) sets the next period to 7. A history of 10 (early) sets it to 5. Any other history sets it to 6.
- R5: The decoded bit is 1 when the decision sample equals the previous decision sample, and 0 otherwise. The previous decision sample and the previous sample are both 0 after reset.
- R6: Sixteen decoded bits form one word, with the first bit at word bit 0. `word_valid_o` rises in the cycle after the 16th decision's sampling edge, and `word_o` holds the word until the next one.
- R7: `word_valid_o` is high for exactly one cycle per word.
- R8: `corr_o` adds 1 on each late correction and subtracts 1 on each early one, saturating at the largest positive and most negative values. `clr_corr_i` forces it to 0 on the next edge and takes priority over a correction. It is otherwise unchanged.
- R9: After reset, `word_valid_o` is 0, `word_o` is 0 and `corr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| tick_i | input | 1 | Base timing tick, one cycle per tick |
| line_i | input | 1 | Hard-limited demodulator output |
| mode_hw_i | input | 1 | 0: software mode, 1: hardware-squelch mode; change only in reset |
| clr_corr_i | input | 1 | Clear the correction counter |
| word_o | output | WORD_W | Last completed word, first bit at bit 0 |
| word_valid_o | output | 1 | One-cycle strobe for a new word |
| corr_o | output | CORR_W | Signed net correction count |

## Verification
On every cycle, the embedded properties check four things: the tick counter stays below the active period, an intermediate sample always restores the nominal period, the software-mode phase wraps after its third sample, and the word strobe is a single-cycle pulse that follows a decision. They also check that the correction counter clears on request and changes only at decisions. Other behaviour can only be shown by the bench's scenarios: which tick the first word lands on in each mode, the exact period chosen for each history pattern, NRZI polarity, bit order within a word, and saturation of the counter. The bench covers these with aligned single-transition runs and with drifting random symbol streams, and compares every cycle against a behavioural model.

// File: rtl/dpll_nrzi_pkg.sv
package dpll_nrzi_pkg;
  // Pending adjustment of the next sample period
  typedef enum logic [1:0] {
    ADJ_NOM   = 2'd0,
    ADJ_LONG  = 2'd1,
    ADJ_SHORT = 2'd2
  } adj_e;
endpackage

// File: rtl/rx_sample_timer.sv
module rx_sample_timer
  import dpll_nrzi_pkg::*;
#(
  parameter int NOM_SW = 4,
  parameter int NOM_HW = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic mode_hw_i,
  input  adj_e adj_i,
  output logic sample_o
);
  localparam int MAXP  = (NOM_HW > NOM_SW ? NOM_HW : NOM_SW) + 1;
  localparam int CNT_W = $clog2(MAXP + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d, base, period;

  always_comb begin
    base = mode_hw_i ? CNT_W'(NOM_HW) : CNT_W'(NOM_SW);
    unique case (adj_i)
      ADJ_LONG:  period = base + CNT_W'(1);
      ADJ_SHORT: period = base - CNT_W'(1);
      default:   period = base;
    endcase
  end

  assign sample_o = tick_i && (cnt_q == period - CNT_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (tick_i) begin
      cnt_d = sample_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  AST_CNT_BELOW_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < period); // R1
endmodule

// File: rtl/rx_phase_ctrl.sv
module rx_phase_ctrl
  import dpll_nrzi_pkg::*;
#(
  parameter int CORR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              line_i,
  input  logic              mode_hw_i,
  input  logic              clr_corr_i,
  output adj_e              adj_o,
  output logic              decide_o,
  output logic [CORR_W-1:0] corr_o
);
  localparam int HIST_W = 3;
  localparam logic [CORR_W-1:0] CMAX = {1'b0, {(CORR_W-1){1'b1}}};
  localparam logic [CORR_W-1:0] CMIN = {1'b1, {(CORR_W-1){1'b0}}};

  logic [1:0]        phase_q, phase_d;
  logic              last_q, last_d;
  logic [HIST_W-1:0] hist_q, hist_d;
  adj_e              adj_q, adj_d;
  logic [CORR_W-1:0] corr_q, corr_d;
  logic              late, early;

  assign decide_o = sample_i && (phase_q == 2'd0);

  always_comb begin
    phase_d = phase_q;
    last_d  = last_q;
    hist_d  = hist_q;
    adj_d   = adj_q;
    if (sample_i) begin
      last_d = line_i;
      hist_d = {hist_q[HIST_W-2:0], line_i ^ last_q};
      if (!decide_o) begin
        adj_d = ADJ_NOM;
      end else if (mode_hw_i) begin
        unique case (hist_d[1:0])
          2'b01:   adj_d = ADJ_LONG;
          2'b10:   adj_d = ADJ_SHORT;
          default: adj_d = ADJ_NOM;
        endcase
      end else begin
        unique case (hist_d)
          3'b001:  adj_d = ADJ_LONG;
          3'b100:  adj_d = ADJ_SHORT;
          default: adj_d = ADJ_NOM;
        endcase
      end
      if (mode_hw_i) phase_d = (phase_q == 2'd0) ? 2'd1 : 2'd0;
      else           phase_d = (phase_q == 2'd2) ? 2'd0 : phase_q + 2'd1;
    end
  end

  assign late  = decide_o && (adj_d == ADJ_LONG);
  assign early = decide_o && (adj_d == ADJ_SHORT);

  always_comb begin
    corr_d = corr_q;
    if (clr_corr_i)                   corr_d = '0;
    else if (late && corr_q != CMAX)  corr_d = corr_q + CORR_W'(1);
    else if (early && corr_q != CMIN) corr_d = corr_q - CORR_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 2'd0;
      last_q  <= 1'b0;
      hist_q  <= '0;
      adj_q   <= ADJ_NOM;
      corr_q  <= '0;
    end else begin
      phase_q <= phase_d;
      last_q  <= last_d;
      hist_q  <= hist_d;
      adj_q   <= adj_d;
      corr_q  <= corr_d;
    end
  end

  assign adj_o  = adj_q;
  assign corr_o = corr_q;

  AST_INTERM_NOMINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && phase_q != 2'd0) |=> adj_q == ADJ_NOM); // R2
  AST_PHASE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !mode_hw_i && phase_q == 2'd2) |=> phase_q == 2'd0); // R1
  AST_CORR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_corr_i |=> corr_q == '0); // R8
  AST_CORR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_corr_i && !decide_o) |=> $stable(corr_q)); // R8
endmodule

// File: rtl/rx_nrzi_packer.sv
module rx_nrzi_packer #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              decide_i,
  input  logic              line_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  localparam int SR_W = WORD_W + 1;
  localparam logic [SR_W-1:0] MARK = {1'b1, {WORD_W{1'b0}}};

  logic [SR_W-1:0]   sr_q, sr_d, sr_sh;
  logic              prev_q, prev_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              valid_q, valid_d;
  logic              nrzi_bit;

  assign nrzi_bit = (line_i == prev_q);
  assign sr_sh    = {nrzi_bit, sr_q[SR_W-1:1]};

  always_comb begin
    sr_d    = sr_q;
    prev_d  = prev_q;
    word_d  = word_q;
    valid_d = 1'b0;
    if (decide_i) begin
      prev_d = line_i;
      if (sr_sh[0]) begin
        word_d  = sr_sh[SR_W-1:1];
        valid_d = 1'b1;
        sr_d    = MARK;
      end else begin
        sr_d = sr_sh;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= MARK;
      prev_q  <= 1'b0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      sr_q    <= sr_d;
      prev_q  <= prev_d;
      word_q  <= word_d;
      valid_q <= valid_d;
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R7
  AST_VALID_AFTER_DECIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> $past(decide_i)); // R6
  AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> $stable(word_q)); // R6
endmodule

// File: rtl/dpll_nrzi_rx.sv
module dpll_nrzi_rx
  import dpll_nrzi_pkg::*;
#(
  parameter int NOM_SW = 4,
  parameter int NOM_HW = 6,
  parameter int WORD_W = 16,
  parameter int CORR_W = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic                     line_i,
  input  logic                     mode_hw_i,
  input  logic                     clr_corr_i,
  output logic [WORD_W-1:0]        word_o,
  output logic                     word_valid_o,
  output logic signed [CORR_W-1:0] corr_o
);
  adj_e              adj;
  logic              sample;
  logic              decide;
  logic [CORR_W-1:0] corr;

  rx_sample_timer #(.NOM_SW(NOM_SW), .NOM_HW(NOM_HW)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .mode_hw_i (mode_hw_i),
    .adj_i     (adj),
    .sample_o  (sample)
  );

  rx_phase_ctrl #(.CORR_W(CORR_W)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample),
    .line_i     (line_i),
    .mode_hw_i  (mode_hw_i),
    .clr_corr_i (clr_corr_i),
    .adj_o      (adj),
    .decide_o   (decide),
    .corr_o     (corr)
  );

  rx_nrzi_packer #(.WORD_W(WORD_W)) u_pack (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .decide_i (decide),
    .line_i   (line_i),
    .word_o   (word_o),
    .valid_o  (word_valid_o)
  );

  assign corr_o = $signed(corr);
endmodule

// File: tb/dpll_nrzi_rx_tb.sv
`timescale 1ns/1ps
module dpll_nrzi_rx_tb;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n, tick, line, mode_hw, clr;
  logic [15:0] word;
  logic valid;
  logic signed [CW-1:0] corr;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dpll_nrzi_rx #(.CORR_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .line_i(line),
    .mode_hw_i(mode_hw), .clr_corr_i(clr),
    .word_o(word), .word_valid_o(valid), .corr_o(corr)
  );

  // behavioural reference model
  int m_cnt, m_adj, m_phase, m_hist, m_last, m_prev, m_sr, m_word, m_valid, m_corr;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_adj = 0; m_phase = 0; m_hist = 0; m_last = 0; m_prev = 0;
      m_sr = 1 << 16; m_word = 0; m_valid = 0; m_corr = 0;
    end else begin
      int per;
      bit samp, late, early;
      m_valid = 0; late = 0; early = 0;
      per  = (mode_hw ? 6 : 4) + m_adj;
      samp = tick && (m_cnt == per - 1);
      if (tick) m_cnt = samp ? 0 : m_cnt + 1;
      if (samp) begin
        m_hist = ((m_hist << 1) | (int'(line) != m_last)) & 7;
        m_last = int'(line);
        if (m_phase == 0) begin
          int pat;
          pat = mode_hw ? (m_hist & 3) : m_hist;
          m_adj = 0;
          if (pat == 1) begin m_adj = 1; late = 1; end
          else if (pat == (mode_hw ? 2 : 4)) begin m_adj = -1; early = 1; end
          m_sr = (m_sr >> 1) | ((int'(line) == m_prev) << 16);
          m_prev = int'(line);
          if (m_sr & 1) begin
            m_word = (m_sr >> 1) & 16'hFFFF; m_valid = 1; m_sr = 1 << 16;
          end
        end else m_adj = 0;
        m_phase = mode_hw ? (m_phase == 0 ? 1 : 0) : (m_phase + 1) % 3;
      end
      if (clr) m_corr = 0;
      else if (late && m_corr < 7) m_corr++;
      else if (early && m_corr > -8) m_corr--;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  // drive at a negedge, then observe at the next negedge
  task automatic cyc(input logic t, input logic ln, input logic c);
    tick = t; line = ln; clr = c;
    @(negedge clk);
    if (rst_n) begin
      chk("R6/R7 word_valid vs model", int'(valid), m_valid);
      chk("R5/R6 word vs model", int'(word), m_word);
      chk("R3/R4/R8 corr vs model", int'(corr), m_corr);
    end
  endtask

  task automatic do_reset(input logic hw);
    rst_n = 1'b0; tick = 0; line = 0; clr = 0; mode_hw = hw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // single transition: line becomes 1 from tick index `from`, run n ticks
  task automatic edge_run(input logic hw, input int from, input int n);
    do_reset(hw);
    for (int i = 1; i <= n; i++) cyc(1'b1, (i >= from), 1'b0);
  endtask

  task automatic rand_stream(input logic hw, input int sym_len, input int gap, input int nsym);
    logic ln = 1'b0;
    do_reset(hw);
    for (int s = 0; s < nsym; s++) begin
      if ($urandom_range(0, 1) == 0) ln = ~ln;
      for (int k = 0; k < sym_len; k++) begin
        cyc(1'b1, ln, 1'b0);
        for (int g = 1; g < gap; g++) cyc(1'b0, ln, (s == nsym / 2) && (k == 0) && (g == 1));
      end
    end
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    do_reset(1'b0);
    @(negedge clk);
    chk("R9 reset valid", int'(valid), 0);
    chk("R9 reset word", int'(word), 0);
    chk("R9 reset corr", int'(corr), 0);

    // R1/R2/R5/R6: constant line, software mode
    n = 0;
    do begin cyc(1'b1, 1'b0, 1'b0); n++; end while (!valid && n < 400);
    chk("R1/R2 sw first word tick", n, 184);
    chk("R5/R6 sw constant line word", int'(word), 16'hFFFF);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R7 valid drops", int'(valid), 0);

    // R1/R2/R5: constant line, hardware-squelch mode
    do_reset(1'b1);
    n = 0;
    do begin cyc(1'b1, 1'b0, 1'b0); n++; end while (!valid && n < 400);
    chk("R1/R2 hw first word tick", n, 186);
    chk("R5/R6 hw constant line word", int'(word), 16'hFFFF);

    // R3: software late and early
    edge_run(1'b0, 14, 17);
    chk("R3 sw late corr", int'(corr), 1);
    edge_run(1'b0, 6, 17);
    chk("R3 sw early corr", int'(corr), -1);
    // R4: hardware-squelch late and early
    edge_run(1'b1, 15, 19);
    chk("R4 hw late corr", int'(corr), 1);
    edge_run(1'b1, 9, 19);
    chk("R4 hw early corr", int'(corr), -1);

    // R8: clear
    cyc(1'b0, 1'b1, 1'b1);
    chk("R8 clear corr", int'(corr), 0);

    // drifting random streams, R1..R8 through the model
    rand_stream(1'b0, 13, 1, 120);
    rand_stream(1'b0, 11, 2, 120);
    rand_stream(1'b1, 11, 1, 120);
    rand_stream(1'b1, 13, 3, 100);
    rand_stream(1'b0, 12, 1, 100);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule